// File: doc/BRIEF.md
# Parallel-Compare Predicate File

This block holds a file of one-bit predicates. Compare operations write the predicates, and other operations read them as qualifying predicates that decide whether they execute. Each cycle up to four compare lanes can be presented at once. Every lane carries its own qualifying-predicate index, two target indices, a relation, a write kind and two 64-bit operands.

The write kind selects how the condition reaches the two targets:
- A plain overwrite.
- An unconditional initialisation.
- Accumulating AND or OR forms, which write the same value to both targets.
- Two complementary forms, which write opposite values to the two targets.

The accumulating forms only ever write one fixed value when they fire. As a result, several of them aimed at the same pair in one cycle combine into the logical AND or OR of all their conditions.

A combinational read port reports whether an operation guarded by a given predicate is enabled. The block accepts every valid lane in every cycle. It has no back-pressure and no ready signal, because a lane never has to wait.

Top module: `pred_file`

## Requirements
- R1: After reset every predicate 1..63 reads 0 and predicate 0 reads 1.
- R2: Predicate 0 always reads 1; any write aimed at index 0 is discarded while the other target of the same compare is still written.
- R3: The relation code selects the condition on the 64-bit operands a and b: 0 = equal, 1 = not equal, 2 = signed a < b, 3 = signed a >= b.
- R4: Kind code 0 (plain): when the lane's qualifying predicate is 1 the first target gets cond and the second gets NOT cond; when it is 0 neither target changes.
- R5: Kind code 1 (unconditional): when the qualifying predicate is 1 it behaves like R4; when it is 0 both targets are cleared to 0.
- R6: Kind code 2 (AND): when the qualifying predicate is 1 and cond is 0, both targets become 0; otherwise neither changes.
- R7: Kind code 3 (OR): when the qualifying predicate is 1 and cond is 1, both targets become 1; otherwise neither changes.
- R8: Kind code 4 (AND with complemented OR) writes first = 0 and second = 1 when the qualifying predicate is 1 and cond is 0. Kind code 5 (OR with complemented AND) writes first = 1 and second = 0 when the qualifying predicate is 1 and cond is 1. Otherwise neither kind changes anything.
- R9: Up to four lanes act in one cycle. Every lane reads its qualifying predicate from the state before that cycle. Same-kind accumulating writes to one pair combine as the AND (kinds 2, 4) or the OR (kinds 3, 5) of all lane conditions.
- R10: When lanes in one cycle write different values to the same predicate, the highest-numbered lane wins; within one lane the second target wins over the first.
- R11: rd_en equals the current value of predicate rd_idx with no clock delay; a compare's effect appears there only after the clock edge that takes it.
- R12: A lane with valid low, or with kind code 6 or 7, changes no predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 4 | Per-lane compare valid |
| cmp_qp | input | 4x6 | Per-lane qualifying predicate index |
| cmp_p1 | input | 4x6 | Per-lane first target index |
| cmp_p2 | input | 4x6 | Per-lane second target index |
| cmp_rel | input | 4x2 | Per-lane relation code |
| cmp_kind | input | 4x3 | Per-lane write kind code |
| cmp_a | input | 4x64 | Per-lane operand a |
| cmp_b | input | 4x64 | Per-lane operand b |
| rd_idx | input | 6 | Guard predicate index to read |
| rd_en | output | 1 | Value of that predicate (operation enabled) |

## Verification
A compare presented in one cycle changes the predicate file at the next rising edge. The read port is combinational, so its effect is due on rd_en from that edge onward and not before it. The bench drives each lane set 1 ns after a rising edge and lets the next edge take it. It then drops the lanes and steps rd_idx through the targets, sampling 1 ns after each change, well clear of any edge. One directed check reads a target before the taking edge to confirm that the old value is still shown.

// File: rtl/pred_pkg.sv
package pred_pkg;
  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_NE = 2'd1,
    REL_LT = 2'd2,
    REL_GE = 2'd3
  } cmp_rel_e;

  typedef enum logic [2:0] {
    K_PLAIN   = 3'd0,
    K_UNCOND  = 3'd1,
    K_AND     = 3'd2,
    K_OR      = 3'd3,
    K_AND_ORC = 3'd4,
    K_OR_ANDC = 3'd5
  } cmp_kind_e;
endpackage

// File: rtl/pred_cmp_eval.sv
module pred_cmp_eval #(
  parameter int DATA_W = 64
) (
  input  logic              valid,
  input  logic              qp_val,
  input  logic [1:0]        rel,
  input  logic [2:0]        kind,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              cond,
  output logic              w1_en,
  output logic              w1_val,
  output logic              w2_en,
  output logic              w2_val
);
  import pred_pkg::*;

  // relation evaluation (R3)
  always_comb begin
    case (rel)
      REL_EQ:  cond = (a == b);
      REL_NE:  cond = (a != b);
      REL_LT:  cond = ($signed(a) <  $signed(b));
      default: cond = ($signed(a) >= $signed(b));
    endcase
  end

  // write-kind decode (R4..R8, R12)
  always_comb begin
    w1_en  = 1'b0;
    w1_val = 1'b0;
    w2_en  = 1'b0;
    w2_val = 1'b0;
    if (valid) begin
      case (kind)
        K_PLAIN: begin
          w1_en  = qp_val;
          w2_en  = qp_val;
          w1_val = cond;
          w2_val = !cond;
        end
        K_UNCOND: begin
          w1_en  = 1'b1;
          w2_en  = 1'b1;
          w1_val = qp_val & cond;
          w2_val = qp_val & !cond;
        end
        K_AND: begin
          w1_en  = qp_val & !cond;
          w2_en  = qp_val & !cond;
        end
        K_OR: begin
          w1_en  = qp_val & cond;
          w2_en  = qp_val & cond;
          w1_val = 1'b1;
          w2_val = 1'b1;
        end
        K_AND_ORC: begin
          w1_en  = qp_val & !cond;
          w2_en  = qp_val & !cond;
          w2_val = 1'b1;
        end
        K_OR_ANDC: begin
          w1_en  = qp_val & cond;
          w2_en  = qp_val & cond;
          w1_val = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pred_merge.sv
module pred_merge #(
  parameter int NUM_PRED = 64,
  parameter int LANES    = 4,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic [LANES-1:0][IDX_W-1:0] idx1,
  input  logic [LANES-1:0]            en1,
  input  logic [LANES-1:0]            val1,
  input  logic [LANES-1:0][IDX_W-1:0] idx2,
  input  logic [LANES-1:0]            en2,
  input  logic [LANES-1:0]            val2,
  output logic [NUM_PRED-1:1]         wr_en,
  output logic [NUM_PRED-1:1]         wr_val
);
  // entry 0 has no write path at all (R2)
  for (genvar g = 1; g < NUM_PRED; g++) begin : g_entry
    always_comb begin
      wr_en[g]  = 1'b0;
      wr_val[g] = 1'b0;
      // later lanes override earlier ones; second target overrides first (R10)
      for (int l = 0; l < LANES; l++) begin
        if (en1[l] && idx1[l] == IDX_W'(g)) begin
          wr_en[g]  = 1'b1;
          wr_val[g] = val1[l];
        end
        if (en2[l] && idx2[l] == IDX_W'(g)) begin
          wr_en[g]  = 1'b1;
          wr_val[g] = val2[l];
        end
      end
    end
  end
endmodule

// File: rtl/pred_file.sv
module pred_file #(
  parameter int NUM_PRED = 64,
  parameter int LANES    = 4,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             cmp_valid,
  input  logic [LANES-1:0][IDX_W-1:0]  cmp_qp,
  input  logic [LANES-1:0][IDX_W-1:0]  cmp_p1,
  input  logic [LANES-1:0][IDX_W-1:0]  cmp_p2,
  input  logic [LANES-1:0][1:0]        cmp_rel,
  input  logic [LANES-1:0][2:0]        cmp_kind,
  input  logic [LANES-1:0][DATA_W-1:0] cmp_a,
  input  logic [LANES-1:0][DATA_W-1:0] cmp_b,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic                         rd_en
);
  logic [NUM_PRED-1:1] pred_store;
  logic [NUM_PRED-1:0] pred_view;
  logic [LANES-1:0]    lane_q;
  logic [LANES-1:0]    lane_cond;
  logic [LANES-1:0]    w1_en, w1_val, w2_en, w2_val;
  logic [NUM_PRED-1:1] wr_en, wr_val;

  // predicate 0 is a hard-wired one (R2)
  assign pred_view = {pred_store, 1'b1};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // qualifying predicate read from pre-cycle state (R9)
    assign lane_q[l] = pred_view[cmp_qp[l]];

    pred_cmp_eval #(.DATA_W(DATA_W)) u_eval (
      .valid  (cmp_valid[l]),
      .qp_val (lane_q[l]),
      .rel    (cmp_rel[l]),
      .kind   (cmp_kind[l]),
      .a      (cmp_a[l]),
      .b      (cmp_b[l]),
      .cond   (lane_cond[l]),
      .w1_en  (w1_en[l]),
      .w1_val (w1_val[l]),
      .w2_en  (w2_en[l]),
      .w2_val (w2_val[l])
    );
  end

  pred_merge #(.NUM_PRED(NUM_PRED), .LANES(LANES)) u_merge (
    .idx1   (cmp_p1),
    .en1    (w1_en),
    .val1   (w1_val),
    .idx2   (cmp_p2),
    .en2    (w2_en),
    .val2   (w2_val),
    .wr_en  (wr_en),
    .wr_val (wr_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_store <= '0;
    end else begin
      for (int i = 1; i < NUM_PRED; i++) begin
        if (wr_en[i]) pred_store[i] <= wr_val[i];
      end
    end
  end

  // guard read port (R11)
  assign rd_en = pred_view[rd_idx];
endmodule

// File: rtl/pred_file_chk.sv
module pred_file_chk #(
  parameter int NUM_PRED = 64,
  parameter int LANES    = 4,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [LANES-1:0]            cmp_valid,
  input logic [LANES-1:0][IDX_W-1:0] cmp_p1,
  input logic [LANES-1:0][IDX_W-1:0] cmp_p2,
  input logic [LANES-1:0][2:0]       cmp_kind,
  input logic [LANES-1:0]            lane_q,
  input logic [LANES-1:0]            lane_cond,
  input logic [IDX_W-1:0]            rd_idx,
  input logic                        rd_en,
  input logic [NUM_PRED-1:0]         pred_view
);
  localparam logic [LANES-1:0] ONLY0 = LANES'(1);

  p_zero_reads_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0) |-> rd_en);

  p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid == '0) |=> (pred_view == $past(pred_view)));

  p_plain_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid == ONLY0 && cmp_kind[0] == 3'd0 && !lane_q[0])
    |=> (pred_view == $past(pred_view)));

  p_uncond_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid == ONLY0 && cmp_kind[0] == 3'd1 && !lane_q[0] && cmp_p1[0] != '0)
    |=> !pred_view[$past(cmp_p1[0])]);

  p_and_false_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid == ONLY0 && cmp_kind[0] == 3'd2 && lane_q[0] && !lane_cond[0]
     && cmp_p2[0] != '0)
    |=> !pred_view[$past(cmp_p2[0])]);

  p_or_true_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid == ONLY0 && cmp_kind[0] == 3'd3 && lane_q[0] && lane_cond[0]
     && cmp_p1[0] != '0)
    |=> pred_view[$past(cmp_p1[0])]);
endmodule

bind pred_file pred_file_chk #(.NUM_PRED(NUM_PRED), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_valid (cmp_valid),
  .cmp_p1    (cmp_p1),
  .cmp_p2    (cmp_p2),
  .cmp_kind  (cmp_kind),
  .lane_q    (lane_q),
  .lane_cond (lane_cond),
  .rd_idx    (rd_idx),
  .rd_en     (rd_en),
  .pred_view (pred_view)
);

// File: tb/pred_file_tb.sv
`timescale 1ns/1ps
module pred_file_tb;
  localparam int NP = 64;
  localparam int NL = 4;
  localparam int DW = 64;
  localparam int IW = 6;
  localparam logic [63:0] MINUS1 = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0]         cmp_valid;
  logic [NL-1:0][IW-1:0] cmp_qp, cmp_p1, cmp_p2;
  logic [NL-1:0][1:0]    cmp_rel;
  logic [NL-1:0][2:0]    cmp_kind;
  logic [NL-1:0][DW-1:0] cmp_a, cmp_b;
  logic [IW-1:0]         rd_idx;
  logic                  rd_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  pred_file u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_qp(cmp_qp),
    .cmp_p1(cmp_p1), .cmp_p2(cmp_p2), .cmp_rel(cmp_rel), .cmp_kind(cmp_kind),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .rd_idx(rd_idx), .rd_en(rd_en)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic [1:0]  rel;
    logic [5:0]  qp;
    logic [5:0]  p1;
    logic [5:0]  p2;
    logic [63:0] a;
    logic [63:0] b;
    logic        e1;
    logic        e2;
  } vec_t;

  // single-lane vectors, applied in order; expected values follow the state chain
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 6'd0, 6'd1,  6'd2,  64'd5,  64'd5,  1'b1, 1'b0}, // R4 qp=1 eq true
    '{3'd0, 2'd0, 6'd2, 6'd1,  6'd2,  64'd5,  64'd6,  1'b1, 1'b0}, // R4 qp=0 no write
    '{3'd1, 2'd3, 6'd2, 6'd1,  6'd2,  64'd5,  64'd6,  1'b0, 1'b0}, // R5 qp=0 clears
    '{3'd1, 2'd2, 6'd0, 6'd3,  6'd4,  MINUS1, 64'd1,  1'b1, 1'b0}, // R3 signed lt
    '{3'd1, 2'd3, 6'd0, 6'd5,  6'd6,  MINUS1, 64'd1,  1'b0, 1'b1}, // R3 signed ge false
    '{3'd2, 2'd0, 6'd0, 6'd3,  6'd4,  64'd1,  64'd2,  1'b0, 1'b0}, // R6 false clears
    '{3'd3, 2'd1, 6'd0, 6'd3,  6'd4,  64'd1,  64'd2,  1'b1, 1'b1}, // R7 ne true sets
    '{3'd2, 2'd0, 6'd0, 6'd3,  6'd4,  64'd7,  64'd7,  1'b1, 1'b1}, // R6 true holds
    '{3'd3, 2'd0, 6'd0, 6'd5,  6'd6,  64'd1,  64'd2,  1'b0, 1'b1}, // R7 false holds
    '{3'd4, 2'd0, 6'd0, 6'd3,  6'd5,  64'd1,  64'd2,  1'b0, 1'b1}, // R8 and-orcm
    '{3'd5, 2'd1, 6'd0, 6'd7,  6'd4,  64'd1,  64'd2,  1'b1, 1'b0}, // R8 or-andcm
    '{3'd5, 2'd1, 6'd3, 6'd8,  6'd9,  64'd1,  64'd2,  1'b0, 1'b0}, // R8 qp=0 holds
    '{3'd0, 2'd0, 6'd0, 6'd0,  6'd10, 64'd1,  64'd2,  1'b1, 1'b1}, // R2 write to p0
    '{3'd6, 2'd0, 6'd0, 6'd11, 6'd12, 64'd1,  64'd1,  1'b0, 1'b0}, // R12 kind 6
    '{3'd0, 2'd3, 6'd0, 6'd13, 6'd14, 64'd1,  MINUS1, 1'b1, 1'b0}  // R3 signed ge true
  };

  function automatic string tag_of(logic [2:0] k);
    case (k)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4, 3'd5: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic clear_lanes();
    cmp_valid = '0;
    cmp_qp = '0; cmp_p1 = '0; cmp_p2 = '0;
    cmp_rel = '0; cmp_kind = '0; cmp_a = '0; cmp_b = '0;
  endtask

  task automatic set_lane(int l, logic [2:0] k, logic [1:0] r, logic [5:0] q,
                          logic [5:0] t1, logic [5:0] t2, logic [63:0] a, logic [63:0] b);
    cmp_valid[l] = 1'b1;
    cmp_kind[l] = k; cmp_rel[l] = r; cmp_qp[l] = q;
    cmp_p1[l] = t1; cmp_p2[l] = t2; cmp_a[l] = a; cmp_b[l] = b;
  endtask

  // let the next edge take the lanes, then drop them
  task automatic apply();
    @(posedge clk);
    #1;
    clear_lanes();
  endtask

  task automatic rd_check(logic [5:0] idx, logic exp, string req);
    rd_idx = idx;
    #1;
    checks++;
    if (rd_en !== exp) begin
      errors++;
      $display("FAIL %s: predicate %0d got %0b expected %0b", req, idx, rd_en, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int bad;
    clear_lanes();
    rd_idx = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R1: reset state, scanned through the read port
    bad = 0;
    for (int i = 0; i < NP; i++) begin
      rd_idx = IW'(i);
      #0.1;
      if (rd_en !== (i == 0)) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R1: %0d entries wrong after reset, got mismatches expected 0", bad);
    end

    // vector table, lane 0 only
    for (int v = 0; v < NV; v++) begin
      set_lane(0, VECS[v].kind, VECS[v].rel, VECS[v].qp, VECS[v].p1, VECS[v].p2,
               VECS[v].a, VECS[v].b);
      apply();
      rd_check(VECS[v].p1, VECS[v].e1, tag_of(VECS[v].kind));
      rd_check(VECS[v].p2, VECS[v].e2, tag_of(VECS[v].kind));
    end
    // R2: index 0 still reads 1 after the write aimed at it
    rd_check(6'd0, 1'b1, "R2");

    // R9: four and-orcm lanes, one false -> 20=0, 21=1
    set_lane(0, 3'd1, 2'd0, 6'd0, 6'd20, 6'd21, 64'd0, 64'd0);
    apply();
    set_lane(0, 3'd4, 2'd0, 6'd0, 6'd20, 6'd21, 64'd1, 64'd1);
    set_lane(1, 3'd4, 2'd0, 6'd0, 6'd20, 6'd21, 64'd2, 64'd2);
    set_lane(2, 3'd4, 2'd0, 6'd0, 6'd20, 6'd21, 64'd3, 64'd4);
    set_lane(3, 3'd4, 2'd0, 6'd0, 6'd20, 6'd21, 64'd5, 64'd5);
    apply();
    rd_check(6'd20, 1'b0, "R9");
    rd_check(6'd21, 1'b1, "R9");

    // R9: four and-orcm lanes all true -> pair unchanged at 1,0
    set_lane(0, 3'd1, 2'd0, 6'd0, 6'd20, 6'd21, 64'd0, 64'd0);
    apply();
    for (int l = 0; l < NL; l++) set_lane(l, 3'd4, 2'd0, 6'd0, 6'd20, 6'd21, 64'(l), 64'(l));
    apply();
    rd_check(6'd20, 1'b1, "R9");
    rd_check(6'd21, 1'b0, "R9");

    // R9: four OR lanes, one true -> 22,23 = 1,1
    set_lane(0, 3'd3, 2'd0, 6'd0, 6'd22, 6'd23, 64'd1, 64'd2);
    set_lane(1, 3'd3, 2'd0, 6'd0, 6'd22, 6'd23, 64'd1, 64'd2);
    set_lane(2, 3'd3, 2'd0, 6'd0, 6'd22, 6'd23, 64'd3, 64'd3);
    set_lane(3, 3'd3, 2'd0, 6'd0, 6'd22, 6'd23, 64'd1, 64'd2);
    apply();
    rd_check(6'd22, 1'b1, "R9");
    rd_check(6'd23, 1'b1, "R9");

    // R9: four OR lanes all false -> 28,29 stay 0
    for (int l = 0; l < NL; l++) set_lane(l, 3'd3, 2'd0, 6'd0, 6'd28, 6'd29, 64'd1, 64'd9);
    apply();
    rd_check(6'd28, 1'b0, "R9");
    rd_check(6'd29, 1'b0, "R9");

    // R9: lane 1 guarded by 24, which lane 0 sets in the same cycle -> no write
    set_lane(0, 3'd1, 2'd0, 6'd0, 6'd24, 6'd25, 64'd0, 64'd0);
    set_lane(1, 3'd0, 2'd0, 6'd24, 6'd26, 6'd27, 64'd0, 64'd1);
    apply();
    rd_check(6'd24, 1'b1, "R9");
    rd_check(6'd27, 1'b0, "R9");

    // R10: lane 1 wants 30=1,31=0; lane 3 wants 31=1,30=0; lane 3 wins
    set_lane(1, 3'd0, 2'd0, 6'd0, 6'd30, 6'd31, 64'd4, 64'd4);
    set_lane(3, 3'd0, 2'd0, 6'd0, 6'd31, 6'd30, 64'd4, 64'd4);
    rd_check(6'd31, 1'b0, "R11");  // before the taking edge: old value
    apply();
    rd_check(6'd30, 1'b0, "R10");
    rd_check(6'd31, 1'b1, "R10");
    rd_check(6'd31, 1'b1, "R11");

    // R12: lane 2 carries OR fields but valid is low
    set_lane(2, 3'd3, 2'd0, 6'd0, 6'd32, 6'd33, 64'd1, 64'd1);
    cmp_valid[2] = 1'b0;
    apply();
    rd_check(6'd32, 1'b0, "R12");
    rd_check(6'd33, 1'b0, "R12");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule